// File: doc/BRIEF.md
# Memory-Mapped Request to Packet Address Translator

This block sits between a 32-bit memory-mapped slave port and the header builder of an outbound I/O request path. For each accepted request address it searches a small bank of programmable translation windows, picks one, and produces the 34-bit packet address and the 8-bit target device ID that the packet header needs. One typical setup uses the two top address bits to split the local space into 1 GiB regions, each aimed at a different remote endpoint.

Each window holds a base, a mask, an offset, a two-bit extended-address field and a target ID, and it has an enable bit. The masked upper bits of the request are compared against the base. On a hit, those same bits are replaced by the offset, and the extended field is placed above bit 31. A request that hits no window produces no translated output. Instead, a one-cycle unmapped-error strobe is raised. The result is registered and is handed on through a valid/ready pair.

Top module: `mm2pkt_xlat`

## Requirements
- R1: After reset, pkt_valid and unmap_err are low, req_ready is high, and every window is disabled, so the first request after reset raises unmap_err.
- R2: Window i matches when its enable bit is set and ((req_addr XOR base_i) AND mask_i) is zero.
- R3: The translated address is {xamo, (req_addr AND NOT mask) OR (offset AND mask)}, with xamo in pkt_addr[33:32].
- R4: pkt_dest equals bits [7:0] of the matching window's control register.
- R5: When several windows match, the one with the lowest index is used.
- R6: A window whose control bit 31 (enable) is clear never matches, whatever its base and mask hold.
- R7: An accepted request that matches no window leaves pkt_valid low and pulses unmap_err high for the cycle after acceptance.
- R8: A request accepted at a clock edge appears on pkt_valid, pkt_addr and pkt_dest right after that same edge.
- R9: req_ready is high only when the output stage is empty or pkt_ready is high; while pkt_valid is high and pkt_ready is low, pkt_addr and pkt_dest hold.
- R10: A config write sets one register selected by cfg_addr = {window index, sel}. sel 0 is base, 1 is mask, 2 is offset and 3 is control. Control holds the enable in bit 31, xamo in bits [9:8] and the target ID in bits [7:0]. Requests accepted after the write cycle use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config register write enable |
| cfg_addr | input | 4 | Config register select {window, sel} |
| cfg_wdata | input | 32 | Config write data |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Memory-mapped request address |
| pkt_valid | output | 1 | Translated header fields valid |
| pkt_ready | input | 1 | Downstream takes the translated fields |
| pkt_addr | output | 34 | Translated packet address |
| pkt_dest | output | 8 | Target device ID |
| unmap_err | output | 1 | Request matched no enabled window |

## Verification
A window register that is wrong or stuck shows up on the next translated request through that window. The symptom is a wrong pkt_addr segment, a wrong extended field or a wrong pkt_dest, or an error strobe where a hit was expected. It becomes visible one cycle after that request is accepted. A wrong priority choice only appears when windows overlap, so overlapping windows are set up on purpose. A broken output-stage state shows up at once as a lost or changing header while the stage is stalled, or as req_ready being offered during a stall.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int XLAT_AW      = 32;
  localparam int XAMO_W       = 2;
  localparam int DEST_W       = 8;
  localparam int RIO_AW       = XLAT_AW + XAMO_W;
  localparam int CTL_EN_BIT   = 31;
  localparam int CTL_XAMO_LSB = 8;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_OFFS = 2'd2,
    SEL_CTRL = 2'd3
  } win_sel_e;

  typedef struct packed {
    logic [XLAT_AW-1:0] base;
    logic [XLAT_AW-1:0] mask;
    logic [XLAT_AW-1:0] offset;
    logic               en;
    logic [XAMO_W-1:0]  xamo;
    logic [DEST_W-1:0]  dest;
  } xlat_win_t;
endpackage

// File: rtl/xlat_win_regs.sv
module xlat_win_regs
  import xlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CAW = IDX_W + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CAW-1:0]              cfg_addr,
  input  logic [XLAT_AW-1:0]          cfg_wdata,
  output xlat_win_t [NUM_WIN-1:0]     win_o
);
  win_sel_e         sel;
  logic [IDX_W-1:0] idx;

  assign sel = win_sel_e'(cfg_addr[1:0]);
  assign idx = cfg_addr[CAW-1:2];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    xlat_win_t win_q;
    xlat_win_t win_d;
    logic      wr_en;

    assign wr_en = cfg_we && (idx == IDX_W'(g));

    always_comb begin
      win_d = win_q;
      unique case (sel)
        SEL_BASE: win_d.base   = cfg_wdata;
        SEL_MASK: win_d.mask   = cfg_wdata;
        SEL_OFFS: win_d.offset = cfg_wdata;
        SEL_CTRL: begin
          win_d.en   = cfg_wdata[CTL_EN_BIT];
          win_d.xamo = cfg_wdata[CTL_XAMO_LSB +: XAMO_W];
          win_d.dest = cfg_wdata[DEST_W-1:0];
        end
        default: win_d = win_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q <= '0;
      end else if (wr_en) begin
        win_q <= win_d;
      end
    end

    assign win_o[g] = win_q;
  end
endmodule

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic [XLAT_AW-1:0]      req_addr,
  input  xlat_win_t [NUM_WIN-1:0] win_i,
  output logic                    hit,
  output logic [NUM_WIN-1:0]      grant,
  output logic [RIO_AW-1:0]       xl_addr,
  output logic [DEST_W-1:0]       xl_dest
);
  logic [NUM_WIN-1:0] hit_vec;
  xlat_win_t          sel_win;
  logic               taken;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign hit_vec[g] = win_i[g].en &&
                        (((req_addr ^ win_i[g].base) & win_i[g].mask) == '0);
  end

  // lowest index has priority
  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_vec[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    sel_win = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant[i]) sel_win = sel_win | win_i[i];
    end
  end

  assign hit     = |hit_vec;
  assign xl_addr = {sel_win.xamo,
                    (req_addr & ~sel_win.mask) | (sel_win.offset & sel_win.mask)};
  assign xl_dest = sel_win.dest;
endmodule

// File: rtl/xlat_out_stage.sv
module xlat_out_stage
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              hit,
  input  logic [RIO_AW-1:0] xl_addr,
  input  logic [DEST_W-1:0] xl_dest,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [RIO_AW-1:0] pkt_addr,
  output logic [DEST_W-1:0] pkt_dest,
  output logic              unmap_err
);
  logic              vld_q, vld_d;
  logic              err_q, err_d;
  logic [RIO_AW-1:0] addr_q;
  logic [DEST_W-1:0] dest_q;
  logic              accept;
  logic              load_en;

  assign req_ready = !vld_q || pkt_ready;
  assign accept    = req_valid && req_ready;
  assign load_en   = accept && hit;

  always_comb begin
    vld_d = vld_q;
    if (accept)         vld_d = hit;
    else if (pkt_ready) vld_d = 1'b0;
    err_d = accept && !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dest_q <= '0;
    end else if (load_en) begin
      addr_q <= xl_addr;
      dest_q <= xl_dest;
    end
  end

  assign pkt_valid = vld_q;
  assign pkt_addr  = addr_q;
  assign pkt_dest  = dest_q;
  assign unmap_err = err_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_addr) && $stable(pkt_dest)));

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmap_err |-> !pkt_valid);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unmap_err) |-> $past(req_valid && req_ready));

  // R8
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> $past(req_valid && req_ready));
endmodule

// File: rtl/mm2pkt_xlat.sv
module mm2pkt_xlat
  import xlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CAW = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CAW-1:0]     cfg_addr,
  input  logic [XLAT_AW-1:0] cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [XLAT_AW-1:0] req_addr,
  output logic               pkt_valid,
  input  logic               pkt_ready,
  output logic [RIO_AW-1:0]  pkt_addr,
  output logic [DEST_W-1:0]  pkt_dest,
  output logic               unmap_err
);
  xlat_win_t [NUM_WIN-1:0] win;
  logic                    hit;
  logic [NUM_WIN-1:0]      grant;
  logic [RIO_AW-1:0]       xl_addr;
  logic [DEST_W-1:0]       xl_dest;

  xlat_win_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .win_o     (win)
  );

  xlat_match #(.NUM_WIN(NUM_WIN)) u_match (
    .req_addr (req_addr),
    .win_i    (win),
    .hit      (hit),
    .grant    (grant),
    .xl_addr  (xl_addr),
    .xl_dest  (xl_dest)
  );

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($onehot0(grant) && (hit == (grant != '0))));

  xlat_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .hit       (hit),
    .xl_addr   (xl_addr),
    .xl_dest   (xl_dest),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .pkt_addr  (pkt_addr),
    .pkt_dest  (pkt_dest),
    .unmap_err (unmap_err)
  );
endmodule

// File: tb/tb_mm2pkt_xlat.sv
module tb_mm2pkt_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        pkt_valid;
  logic        pkt_ready = 1'b1;
  logic [33:0] pkt_addr;
  logic [7:0]  pkt_dest;
  logic        unmap_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mm2pkt_xlat dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_addr(pkt_addr), .pkt_dest(pkt_dest), .unmap_err(unmap_err)
  );

  // {req_addr, expect_hit, expect_addr, expect_dest}
  localparam int NV = 8;
  localparam logic [74:0] VEC [NV] = '{
    {32'h4000_1234, 1'b1, 34'h0_0000_1234, 8'h55},
    {32'h7FFF_FFFC, 1'b1, 34'h0_3FFF_FFFC, 8'h55},
    {32'h8000_0000, 1'b1, 34'h0_4000_0000, 8'h66},
    {32'hBFFF_FFFF, 1'b1, 34'h0_7FFF_FFFF, 8'h66},
    {32'hC000_0010, 1'b1, 34'h0_8000_0010, 8'h77},
    {32'h0000_0000, 1'b0, 34'h0,           8'h00},
    {32'h3FFF_FFFF, 1'b0, 34'h0,           8'h00},
    {32'hFFFF_FFFF, 1'b1, 34'h0_BFFF_FFFF, 8'h77}
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wcfg(input int w, input int s, input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 4'((w << 2) | s);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_hit(input string rq, input logic [33:0] a, input logic [7:0] d);
    chk({rq, " valid"}, 64'(pkt_valid), 64'd1);
    chk({rq, " addr"},  64'(pkt_addr),  64'(a));
    chk({rq, " dest"},  64'(pkt_dest),  64'(d));
    chk({rq, " err"},   64'(unmap_err), 64'd0);
  endtask

  task automatic expect_miss(input string rq);
    chk({rq, " valid"}, 64'(pkt_valid), 64'd0);
    chk({rq, " err"},   64'(unmap_err), 64'd1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 pkt_valid", 64'(pkt_valid), 64'd0);
    chk("R1 unmap_err", 64'(unmap_err), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    send(32'h4000_0000);
    expect_miss("R1 disabled after reset");

    // R10: program three windows
    wcfg(0, 0, 32'h4000_0000); wcfg(0, 1, 32'hC000_0000);
    wcfg(0, 2, 32'h0000_0000); wcfg(0, 3, 32'h8000_0055);
    wcfg(1, 0, 32'h8000_0000); wcfg(1, 1, 32'hC000_0000);
    wcfg(1, 2, 32'h4000_0000); wcfg(1, 3, 32'h8000_0066);
    wcfg(2, 0, 32'hC000_0000); wcfg(2, 1, 32'hC000_0000);
    wcfg(2, 2, 32'h8000_0000); wcfg(2, 3, 32'h8000_0077);

    // R2 R3 R4 R7 R8: vector table
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][74:43]);
      if (VEC[i][42]) expect_hit("R2 R3 R4 R8 table", VEC[i][41:8], VEC[i][7:0]);
      else            expect_miss("R7 table");
    end
    @(negedge clk);
    chk("R7 err one cycle", 64'(unmap_err), 64'd0);

    // R9: stall
    pkt_ready = 1'b0;
    send(32'h8000_0004);
    expect_hit("R9 stall load", 34'h0_4000_0004, 8'h66);
    chk("R9 ready low", 64'(req_ready), 64'd0);
    req_valid = 1'b1;
    req_addr  = 32'hC000_0000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expect_hit("R9 held", 34'h0_4000_0004, 8'h66);
      chk("R9 ready held low", 64'(req_ready), 64'd0);
    end
    pkt_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    expect_hit("R9 drain and take", 34'h0_8000_0000, 8'h77);
    @(negedge clk);
    chk("R9 drained", 64'(pkt_valid), 64'd0);

    // R3: extended bits via window 3
    wcfg(3, 0, 32'h0000_0000); wcfg(3, 1, 32'hC000_0000);
    wcfg(3, 2, 32'hC000_0000); wcfg(3, 3, 32'h8000_0399);
    send(32'h0001_0000);
    expect_hit("R3 xamo", 34'h3_C001_0000, 8'h99);

    // R5: overlap windows 0 and 3
    wcfg(3, 0, 32'h4000_0000);
    send(32'h4000_0000);
    expect_hit("R5 lowest wins", 34'h0_0000_0000, 8'h55);

    // R6 R10: disable window 0, window 3 now takes it
    wcfg(0, 3, 32'h0000_0055);
    send(32'h4000_0020);
    expect_hit("R6 R10 win0 off", 34'h3_C000_0020, 8'h99);

    // R6: disable window 3 as well
    wcfg(3, 3, 32'h0000_0399);
    send(32'h4000_0020);
    expect_miss("R6 all off");

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule